// File: doc/BRIEF.md
# Register Bounds Check Unit

This unit decides whether one register value falls inside an inclusive range. The range comes as a pair: a lower bound and then an upper bound. The caller supplies the register value, both bounds, an operation size (byte, word or long), a flag that marks the value as an address or as data, and a flag that selects a signed or an unsigned compare. One cycle after a start strobe, the unit returns a zero flag, a carry flag, an out-of-range indication and a single-cycle done pulse.

How the operands are narrowed depends on what kind of value is checked:

- **Data value:** at byte or word size, only the low-order part of the value and of each bound takes part in the compare.
- **Address value:** each bound is sign-extended from the operation size to 32 bits, and the full 32-bit register is compared against those extended bounds.

The unit does not fetch the bounds from memory and does not handle traps. Both are left to the surrounding logic.

Top module: `bounds_check_unit`

## Requirements
- R1: The size input is decoded as 00 = byte (8 bits), 01 = word (16 bits) and 10 = long (32 bits). The unused code 11 behaves exactly like long.
- R2: When the address select is low (data value) and the size is byte or word, only bits [7:0] or [15:0] of the value and of both bounds are compared. All higher bits of the three operands have no effect on any output.
- R3: When the address select is high (address value), each bound's low 8 or 16 bits are sign-extended to 32 bits. Any higher bits of the bounds are ignored. The result is compared against all 32 bits of the value. At long size the bounds are used unchanged.
- R4: When the signed select is high, operands are ordered as two's-complement numbers of the compared width.
- R5: When the signed select is low, operands are ordered as unsigned numbers of the compared width.
- R6: The zero flag is set when the compared value equals the lower bound or the upper bound. It is clear otherwise.
- R7: The carry flag and out_of_range are both set when the compared value is below the lower bound or above the upper bound. Both are clear otherwise.
- R8: When the two bounds are equal, exactly one value is in range. That value gives zero = 1 and carry = 0, and its neighbours give carry = 1.
- R9: The zero, carry and out_of_range outputs are registered on the clock edge where start is high, and done is high for exactly the following cycle. While start is low, the three flags hold their values and done is low.
- R10: During reset and after reset, before the first start, done, zero, carry and out_of_range are all low. Reset is asynchronous and active-low, and its release is synchronised inside the unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to evaluate the current inputs |
| value_i | input | 32 | Register value under test |
| lower_i | input | 32 | Lower bound (first element of the pair) |
| upper_i | input | 32 | Upper bound (second element of the pair) |
| size_i | input | 2 | Operation size: 00 byte, 01 word, 10 long |
| is_addr_i | input | 1 | 1 = value is an address, 0 = value is data |
| signed_i | input | 1 | 1 = signed compare, 0 = unsigned compare |
| done_o | output | 1 | Result-valid pulse, one cycle after start |
| zero_o | output | 1 | Value equals one of the bounds |
| carry_o | output | 1 | Value lies outside the range |
| out_of_range_o | output | 1 | Out-of-range indication |

## Verification
The assertions assume that every input is stable and known on any clock edge where start_i is high. They relate the extended operands from the preparation stage to the flags registered one cycle later. The in-range and single-value properties also assume that the lower bound does not exceed the upper bound under the selected ordering.

The stimulus respects this ordering. Every bound pair is drawn in the interpreted domain of the current size and compare mode, with the lower bound taken as the smaller one. The exception is address mode with an unsigned compare, where sign extension can produce inverted pairs. There the bench model still predicts the flags, and the ordering-based assertions only fire on the condition they state.

Inputs change only on the falling clock edge, and start is held high for exactly one cycle at a time.

// File: rtl/bchk_pkg.sv
package bchk_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } bchk_size_e;

  localparam int unsigned OPERAND_CNT = 3;
  localparam int unsigned OP_VALUE    = 0;
  localparam int unsigned OP_LOWER    = 1;
  localparam int unsigned OP_UPPER    = 2;

endpackage

// File: rtl/bchk_operand_prep.sv
module bchk_operand_prep
  import bchk_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned WORD_W   = 16,
  parameter bit          IS_BOUND = 1'b0
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic [1:0]        size_i,
  input  logic              is_addr_i,
  input  logic              signed_i,
  output logic [DATA_W:0]   ext_o
);

  localparam int unsigned BYTE_PAD = DATA_W - BYTE_W;
  localparam int unsigned WORD_PAD = DATA_W - WORD_W;

  logic [DATA_W-1:0] zext_w;
  logic [DATA_W-1:0] sext_w;
  logic [DATA_W-1:0] addr_w;
  logic [DATA_W-1:0] data_w;

  // Narrowing to the operation size, in zero-filled and sign-filled forms.
  always_comb begin
    unique case (bchk_size_e'(size_i))
      SZ_BYTE: begin
        zext_w = {{BYTE_PAD{1'b0}}, raw_i[BYTE_W-1:0]};
        sext_w = {{BYTE_PAD{raw_i[BYTE_W-1]}}, raw_i[BYTE_W-1:0]};
      end
      SZ_WORD: begin
        zext_w = {{WORD_PAD{1'b0}}, raw_i[WORD_W-1:0]};
        sext_w = {{WORD_PAD{raw_i[WORD_W-1]}}, raw_i[WORD_W-1:0]};
      end
      default: begin
        zext_w = raw_i;
        sext_w = raw_i;
      end
    endcase
  end

  // Address path: a bound is sign-extended, the value is taken in full.
  generate
    if (IS_BOUND) begin : g_bound
      assign addr_w = sext_w;
    end else begin : g_value
      assign addr_w = raw_i;
    end
  endgenerate

  // Data path: the low-order field, extended according to the compare mode.
  assign data_w = signed_i ? sext_w : zext_w;

  // One extra top bit so that a single signed compare covers both modes.
  always_comb begin
    if (is_addr_i) begin
      ext_o = {signed_i & addr_w[DATA_W-1], addr_w};
    end else begin
      ext_o = {signed_i & data_w[DATA_W-1], data_w};
    end
  end

endmodule

// File: rtl/bchk_range_cmp.sv
module bchk_range_cmp #(
  parameter int unsigned EXT_W = 33
) (
  input  logic [EXT_W-1:0] val_i,
  input  logic [EXT_W-1:0] lo_i,
  input  logic [EXT_W-1:0] hi_i,
  output logic             below_o,
  output logic             above_o,
  output logic             hit_o
);

  logic lo_eq;
  logic hi_eq;

  always_comb begin
    below_o = $signed(val_i) < $signed(lo_i);
    above_o = $signed(val_i) > $signed(hi_i);
    lo_eq   = (val_i == lo_i);
    hi_eq   = (val_i == hi_i);
    hit_o   = lo_eq | hi_eq;
  end

endmodule

// File: rtl/bounds_check_unit.sv
module bounds_check_unit
  import bchk_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic [DATA_W-1:0] lower_i,
  input  logic [DATA_W-1:0] upper_i,
  input  logic [1:0]        size_i,
  input  logic              is_addr_i,
  input  logic              signed_i,
  output logic              done_o,
  output logic              zero_o,
  output logic              carry_o,
  output logic              out_of_range_o
);

  localparam int unsigned EXT_W = DATA_W + 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_n = rst_sync_q[SYNC_STAGES-1];

  // Operand preparation: value first, then the lower and upper bounds.
  logic [DATA_W-1:0] raw_a [OPERAND_CNT];
  logic [EXT_W-1:0]  ext_a [OPERAND_CNT];

  assign raw_a[OP_VALUE] = value_i;
  assign raw_a[OP_LOWER] = lower_i;
  assign raw_a[OP_UPPER] = upper_i;

  for (genvar gi = 0; gi < OPERAND_CNT; gi++) begin : g_prep
    bchk_operand_prep #(
      .DATA_W  (DATA_W),
      .BYTE_W  (BYTE_W),
      .WORD_W  (WORD_W),
      .IS_BOUND(gi != OP_VALUE)
    ) prep_i (
      .raw_i    (raw_a[gi]),
      .size_i   (size_i),
      .is_addr_i(is_addr_i),
      .signed_i (signed_i),
      .ext_o    (ext_a[gi])
    );
  end

  logic below_w;
  logic above_w;
  logic hit_w;

  bchk_range_cmp #(.EXT_W(EXT_W)) cmp_i (
    .val_i  (ext_a[OP_VALUE]),
    .lo_i   (ext_a[OP_LOWER]),
    .hi_i   (ext_a[OP_UPPER]),
    .below_o(below_w),
    .above_o(above_w),
    .hit_o  (hit_w)
  );

  // Next-state logic.
  logic done_q, zero_q, carry_q, oor_q;
  logic done_d, zero_d, carry_d, oor_d;
  logic flag_en;

  assign flag_en = start_i;

  always_comb begin
    done_d  = start_i;
    zero_d  = zero_q;
    carry_d = carry_q;
    oor_d   = oor_q;
    if (flag_en) begin
      zero_d  = hit_w;
      carry_d = below_w | above_w;
      oor_d   = below_w | above_w;
    end
  end

  // State registers.
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      zero_q  <= 1'b0;
      carry_q <= 1'b0;
      oor_q   <= 1'b0;
    end else begin
      done_q  <= done_d;
      zero_q  <= zero_d;
      carry_q <= carry_d;
      oor_q   <= oor_d;
    end
  end

  assign done_o         = done_q;
  assign zero_o         = zero_q;
  assign carry_o        = carry_q;
  assign out_of_range_o = oor_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i |=> done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !start_i |=> !done_o);

  // R9
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !start_i |=> $stable({zero_o, carry_o, out_of_range_o}));

  // R6
  bound_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i && ((ext_a[OP_VALUE] == ext_a[OP_LOWER]) || (ext_a[OP_VALUE] == ext_a[OP_UPPER]))
    |=> zero_o);

  // R7
  inside_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i && ($signed(ext_a[OP_LOWER]) < $signed(ext_a[OP_VALUE]))
            && ($signed(ext_a[OP_VALUE]) < $signed(ext_a[OP_UPPER]))
    |=> !carry_o && !out_of_range_o && !zero_o);

  // R8
  single_value_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i && (ext_a[OP_LOWER] == ext_a[OP_UPPER]) && (ext_a[OP_VALUE] == ext_a[OP_LOWER])
    |=> zero_o && !carry_o);

  // R10
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_n |-> !done_o && !zero_o && !carry_o && !out_of_range_o);

endmodule

// File: tb/bounds_check_unit_tb.sv
module bounds_check_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i;
  logic [31:0] value_i, lower_i, upper_i;
  logic [1:0]  size_i;
  logic        is_addr_i, signed_i;
  logic        done_o, zero_o, carry_o, out_of_range_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bounds_check_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .value_i(value_i), .lower_i(lower_i), .upper_i(upper_i),
    .size_i(size_i), .is_addr_i(is_addr_i), .signed_i(signed_i),
    .done_o(done_o), .zero_o(zero_o), .carry_o(carry_o),
    .out_of_range_o(out_of_range_o)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] sz);
    return (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
  endfunction

  function automatic longint sx(input logic [31:0] x, input int w);
    longint m = (longint'(1) << w) - 1;
    longint u = longint'(x) & m;
    if (((u >> (w - 1)) & 1) != 0) u = u - (longint'(1) << w);
    return u;
  endfunction

  function automatic longint interp(input logic [31:0] x, input int w, input bit sgn);
    if (sgn) return sx(x, w);
    return longint'(x) & ((longint'(1) << w) - 1);
  endfunction

  function automatic longint bound_of(input logic [31:0] b, input int w, input bit addr, input bit sgn);
    if (addr) return interp(32'(sx(b, w)), 32, sgn);
    return interp(b, w, sgn);
  endfunction

  task automatic run_op(input string req, input logic [31:0] v, input logic [31:0] lo,
                        input logic [31:0] hi, input logic [1:0] sz, input bit addr, input bit sgn);
    int w = width_of(sz);
    longint lv = addr ? interp(v, 32, sgn) : interp(v, w, sgn);
    longint ll = bound_of(lo, w, addr, sgn);
    longint lh = bound_of(hi, w, addr, sgn);
    logic ez = (lv == ll) || (lv == lh);
    logic ec = (lv < ll) || (lv > lh);
    @(negedge clk_i);
    value_i = v; lower_i = lo; upper_i = hi; size_i = sz;
    is_addr_i = addr; signed_i = sgn; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    value_i = ~v; lower_i = ~lo; upper_i = ~hi;
    check("R9", "done", done_o, 1'b1);
    check(req, "zero R6", zero_o, ez);
    check(req, "carry R7", carry_o, ec);
    check(req, "out_of_range R7", out_of_range_o, ec);
    @(negedge clk_i);
    check("R9", "done low", done_o, 1'b0);
    check("R9", "zero held", zero_o, ez);
    check("R9", "carry held", carry_o, ec);
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0;
    value_i = '0; lower_i = '0; upper_i = '0;
    size_i = '0; is_addr_i = 1'b0; signed_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R10", "done in reset", done_o, 1'b0);
    check("R10", "zero in reset", zero_o, 1'b0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R10", "done after reset", done_o, 1'b0);
    check("R10", "zero after reset", zero_o, 1'b0);
    check("R10", "carry after reset", carry_o, 1'b0);
    check("R10", "out_of_range after reset", out_of_range_o, 1'b0);

    for (int a = 0; a < 2; a++) begin
      for (int s = 0; s < 2; s++) begin
        for (int z = 0; z < 3; z++) begin
          int w = width_of(2'(z));
          longint wmax = (longint'(1) << w) - 1;
          longint smin = -(longint'(1) << (w - 1));
          logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : 32'((longint'(1) << w) - 1);
          for (int p = 0; p < 3; p++) begin
            longint plo, phi;
            logic [31:0] blo, bhi;
            string req;
            if (s == 1) begin
              plo = (p == 0) ? -3 : (p == 1) ? 4 : smin + 1;
              phi = (p == 0) ?  5 : (p == 1) ? 4 : -1;
            end else begin
              plo = (p == 0) ? 3 : (p == 1) ? 9 : wmax - 6;
              phi = (p == 0) ? 100 : (p == 1) ? 9 : wmax - 1;
            end
            blo = (32'hC3F0_0F3C & ~mask) | (32'(plo) & mask);
            bhi = (32'h3C0F_F0C3 & ~mask) | (32'(phi) & mask);
            if (p == 1)          req = "R8";
            else if (a == 1)     req = "R3";
            else if (z < 2)      req = "R2";
            else if (s == 1)     req = "R4";
            else                 req = "R5";
            for (int e = 0; e < 2; e++) begin
              for (int d = -2; d <= 2; d++) begin
                logic [31:0] bsel = (e == 0) ? blo : bhi;
                logic [31:0] v;
                if (a == 1) v = 32'(sx(bsel, w) + d);
                else        v = (32'h5A3C_96E1 & ~mask) | (32'(longint'(bsel) + d) & mask);
                run_op(req, v, blo, bhi, 2'(z), a[0], s[0]);
              end
            end
          end
        end
      end
    end

    // R1: code 11 behaves as long (upper bits matter).
    run_op("R1", 32'h0100_0005, 32'h0000_0003, 32'h0000_0010, 2'b11, 1'b0, 1'b0);
    run_op("R1", 32'h0000_0005, 32'h0000_0003, 32'h0000_0010, 2'b11, 1'b0, 1'b0);
    run_op("R1", 32'hFFFF_FFFE, 32'hFFFF_FFF0, 32'h0000_0010, 2'b11, 1'b0, 1'b1);
    run_op("R1", 32'h8000_0000, 32'hFFFF_FFF0, 32'h0000_0010, 2'b11, 1'b1, 1'b1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule